// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block turns one addressing operation of an 8-bit processor with a 16-bit address space into the exact run of bus accesses that the operation needs. It issues one access per cycle, including the dummy reads that the processor makes on the way. At the end it reports the effective address, the byte moved, the updated program counter and the number of bus cycles spent. The instruction decoder starts it with a mode code, a direction, the operand byte that has already been fetched, both index registers, the program counter and the store byte. The ALU then consumes the result.

The block covers page zero with or without an index, absolute addressing with or without an index, indirection through page zero in both orders, the taken relative branch and the indirect jump. Page zero indexing never leaves page zero. When an absolute or post-indexed address crosses a page, the block first touches the address with the uncorrected high byte, which costs one more cycle. Memory answers in the same cycle as the request.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is low and after reset, no bus request is made, done_o is low and ea_o, data_o, pc_o and cycles_o are zero.
- R2: Page zero mode (mode code 0) reads address {0x00, operand} once and finishes with cycles_o = 1.
- R3: Page zero indexed modes (code 1 with X, code 2 with Y) make a dummy read at {0x00, operand} and then access {0x00, (operand + index) mod 256}, with cycles_o = 2. No access in modes 0 to 2 leaves page zero.
- R4: Absolute mode (code 3) reads the high byte at the program counter, returns pc_o = pc + 1 and accesses {high, operand}, with cycles_o = 2.
- R5: An absolute indexed read (code 4 with X, code 5 with Y) reads at {high, (operand + index) mod 256}. If that low-byte sum carries, it reads again at that address + 0x100, with cycles_o = 3 rather than 2. pc_o = pc + 1.
- R6: An indexed write (codes 4, 5, 7 with wr_i = 1) makes a dummy read at the uncorrected address and then writes at the corrected one only when the low-byte sum carries. Otherwise it writes at once. The write is always the last access of the operation.
- R7: Pre-indexed indirect (code 6) makes a dummy read at {0x00, operand}, reads the pointer bytes at {0x00, operand+X} and {0x00, operand+X+1} (both mod 256), then accesses the pointer, with cycles_o = 4.
- R8: Post-indexed indirect (code 7) reads the pointer at {0x00, operand} and {0x00, operand+1 mod 256}, adds Y to the pointer low byte under the rule of R5 or R6, with cycles_o = 3 or 4.
- R9: A taken branch (code 8, operand = signed offset) computes target = pc + offset and makes a dummy read at {pc high, target low}. If the page differs it repeats the same read. ea_o = pc_o = target, with cycles_o = 1 or 2.
- R10: Indirect jump (code 9) reads the pointer high byte at pc, reads the target low byte at the pointer and the target high byte at {pointer high, pointer low + 1 mod 256}. ea_o = pc_o = target, with cycles_o = 3.
- R11: done_o is a one-cycle pulse in the cycle after the last access. cycles_o equals the number of bus cycles. data_o holds the final read byte, or the written byte, and is zero for codes 8 and 9.
- R12: start_i is ignored while busy_o is high.
- R13: Mode codes 10 to 15 make no bus access and finish in the next cycle with cycles_o = 0, ea_o = 0, data_o = 0 and pc_o = pc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| mode_i | input | 4 | Addressing mode code |
| wr_i | input | 1 | Final access is a write |
| opnd_i | input | 8 | First operand byte or branch offset |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| pc_i | input | 16 | Program counter after the operand byte |
| wdata_i | input | 8 | Byte to store |
| bus_req_o | output | 1 | Bus access this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 16 | Access address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address or target |
| data_o | output | 8 | Byte read or written |
| pc_o | output | 16 | Updated program counter |
| cycles_o | output | 3 | Bus cycles used |

## Verification
The assertions check on every cycle that done is a single pulse, that the reported cycle count matches the bus requests seen since the accepted start, and that page zero modes stay in page zero. They also check that a write is final and only occurs in data modes, that unused codes finish at once without a bus access, and that reset leaves the bus quiet. The exact address order, the dummy-read placement at uncorrected addresses, the pointer wrap, the branch and jump targets and the ignored mid-operation start can only be shown by the bench scenarios. The bench compares every access and result against a scoreboard.

// File: rtl/eas_pkg.sv
package eas_pkg;
  typedef enum logic [3:0] {
    M_ZP   = 4'd0,
    M_ZPX  = 4'd1,
    M_ZPY  = 4'd2,
    M_ABS  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_INDX = 4'd6,
    M_INDY = 4'd7,
    M_BR   = 4'd8,
    M_JIND = 4'd9
  } mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HI, S_DZP, S_PLO, S_PHI, S_PRE, S_ACC, S_BR1, S_BR2, S_JLO, S_JHI
  } st_e;
endpackage

// File: rtl/eas_add.sv
module eas_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/eas_bus_gen.sv
module eas_bus_gen
  import eas_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  st_e           st_i,
  input  mode_e         mode_i,
  input  logic          wr_i,
  input  logic [DW-1:0] opnd_i,
  input  logic [DW-1:0] idx_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [DW-1:0] ZPG = '0;

  logic [DW-1:0] zp_idx, zp_idx1, zp_nxt, base_lo1;

  // page-zero pointer arithmetic drops the carry on purpose
  assign zp_idx   = opnd_i + idx_i;
  assign zp_idx1  = zp_idx + DW'(1);
  assign zp_nxt   = opnd_i + DW'(1);
  assign base_lo1 = base_i[DW-1:0] + DW'(1);

  always_comb begin
    req_o   = 1'b1;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (st_i)
      S_HI:  addr_o = pc_i;
      S_DZP: addr_o = {ZPG, opnd_i};
      S_PLO: addr_o = (mode_i == M_INDX) ? {ZPG, zp_idx} : {ZPG, opnd_i};
      S_PHI: addr_o = (mode_i == M_INDX) ? {ZPG, zp_idx1} : {ZPG, zp_nxt};
      S_PRE: addr_o = base_i;
      S_ACC: begin
        addr_o  = base_i;
        we_o    = wr_i;
        wdata_o = wr_i ? wdata_i : '0;
      end
      S_BR1, S_BR2: addr_o = {pc_i[AW-1:DW], base_i[DW-1:0]};
      S_JLO: addr_o = base_i;
      S_JHI: addr_o = {base_i[AW-1:DW], base_lo1};
      default: req_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/eas_ctrl.sv
module eas_ctrl
  import eas_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 3,
  localparam int AW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       mode_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    opnd_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    rdata_i,
  input  logic [DW-1:0]    sum_i,
  input  logic             cout_i,
  output st_e              st_o,
  output mode_e            mode_o,
  output logic             wr_o,
  output logic [DW-1:0]    opnd_o,
  output logic [DW-1:0]    idx_o,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    base_o,
  output logic [DW-1:0]    wdata_o,
  output logic [DW-1:0]    ptr_lo_o,
  output logic             done_o,
  output logic [AW-1:0]    ea_o,
  output logic [DW-1:0]    data_o,
  output logic [AW-1:0]    pcr_o,
  output logic [CNT_W-1:0] cyc_o
);
  st_e              st_q;
  mode_e            mode_q;
  logic             wr_q, carry_q, done_q;
  logic [DW-1:0]    opnd_q, idx_q, wdata_q, ptr_lo_q, data_q;
  logic [AW-1:0]    pc_q, base_q, ea_q, pcr_q;
  logic [CNT_W-1:0] cnt_q, cyc_q;

  mode_e         mode_in;
  logic [AW-1:0] br_tgt;

  assign mode_in = mode_e'(mode_i);
  assign br_tgt  = pc_i + {{DW{opnd_i[DW-1]}}, opnd_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      mode_q   <= M_ZP;
      wr_q     <= 1'b0;
      carry_q  <= 1'b0;
      done_q   <= 1'b0;
      opnd_q   <= '0;
      idx_q    <= '0;
      wdata_q  <= '0;
      ptr_lo_q <= '0;
      data_q   <= '0;
      pc_q     <= '0;
      base_q   <= '0;
      ea_q     <= '0;
      pcr_q    <= '0;
      cnt_q    <= '0;
      cyc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (st_q != S_IDLE) cnt_q <= cnt_q + CNT_W'(1);
      unique case (st_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_in;
          wr_q    <= wr_i;
          opnd_q  <= opnd_i;
          pc_q    <= pc_i;
          wdata_q <= wdata_i;
          cnt_q   <= '0;
          carry_q <= 1'b0;
          unique case (mode_in)
            M_ZPX, M_ABSX, M_INDX: idx_q <= x_i;
            M_ZPY, M_ABSY, M_INDY: idx_q <= y_i;
            default:               idx_q <= '0;
          endcase
          unique case (mode_in)
            M_ZP: begin
              base_q <= {{DW{1'b0}}, opnd_i};
              st_q   <= S_ACC;
            end
            M_ZPX, M_ZPY, M_INDX:        st_q <= S_DZP;
            M_ABS, M_ABSX, M_ABSY, M_JIND: st_q <= S_HI;
            M_INDY:                      st_q <= S_PLO;
            M_BR: begin
              base_q  <= br_tgt;
              carry_q <= br_tgt[AW-1:DW] != pc_i[AW-1:DW];
              st_q    <= S_BR1;
            end
            default: begin
              done_q <= 1'b1;
              ea_q   <= '0;
              data_q <= '0;
              pcr_q  <= pc_i;
              cyc_q  <= '0;
            end
          endcase
        end
        S_HI: begin
          pc_q <= pc_q + AW'(1);
          if (mode_q == M_JIND) begin
            base_q <= {rdata_i, opnd_q};
            st_q   <= S_JLO;
          end else begin
            base_q <= {rdata_i, sum_i};
            st_q   <= cout_i ? S_PRE : S_ACC;
          end
        end
        S_DZP: begin
          if (mode_q == M_INDX) st_q <= S_PLO;
          else begin
            base_q <= {{DW{1'b0}}, sum_i};
            st_q   <= S_ACC;
          end
        end
        S_PLO: begin
          ptr_lo_q <= rdata_i;
          st_q     <= S_PHI;
        end
        S_PHI: begin
          if (mode_q == M_INDX) begin
            base_q <= {rdata_i, ptr_lo_q};
            st_q   <= S_ACC;
          end else begin
            base_q <= {rdata_i, sum_i};
            st_q   <= cout_i ? S_PRE : S_ACC;
          end
        end
        S_PRE: begin
          base_q[AW-1:DW] <= base_q[AW-1:DW] + DW'(1);
          st_q            <= S_ACC;
        end
        S_ACC: begin
          ea_q   <= base_q;
          data_q <= wr_q ? wdata_q : rdata_i;
          pcr_q  <= pc_q;
          cyc_q  <= cnt_q + CNT_W'(1);
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_BR1, S_BR2: begin
          if (st_q == S_BR1 && carry_q) st_q <= S_BR2;
          else begin
            ea_q   <= base_q;
            data_q <= '0;
            pcr_q  <= base_q;
            cyc_q  <= cnt_q + CNT_W'(1);
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        S_JLO: begin
          ptr_lo_q <= rdata_i;
          st_q     <= S_JHI;
        end
        S_JHI: begin
          ea_q   <= {rdata_i, ptr_lo_q};
          data_q <= '0;
          pcr_q  <= {rdata_i, ptr_lo_q};
          cyc_q  <= cnt_q + CNT_W'(1);
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign st_o     = st_q;
  assign mode_o   = mode_q;
  assign wr_o     = wr_q;
  assign opnd_o   = opnd_q;
  assign idx_o    = idx_q;
  assign pc_o     = pc_q;
  assign base_o   = base_q;
  assign wdata_o  = wdata_q;
  assign ptr_lo_o = ptr_lo_q;
  assign done_o   = done_q;
  assign ea_o     = ea_q;
  assign data_o   = data_q;
  assign pcr_o    = pcr_q;
  assign cyc_o    = cyc_q;
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import eas_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 3,
  localparam int AW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       mode_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    opnd_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    y_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    ea_o,
  output logic [DW-1:0]    data_o,
  output logic [AW-1:0]    pc_o,
  output logic [CNT_W-1:0] cycles_o
);
  st_e           st;
  mode_e         mode_q;
  logic          wr_q, cout;
  logic [DW-1:0] opnd_q, idx_q, wdata_q, ptr_lo_q, add_a, sum;
  logic [AW-1:0] pc_q, base_q;

  // post-index add uses the pointer low byte, every other add uses the operand
  assign add_a  = (st == S_PHI) ? ptr_lo_q : opnd_q;
  assign busy_o = st != S_IDLE;

  eas_add #(.W(DW)) u_add (
    .a_i(add_a), .b_i(idx_q), .sum_o(sum), .cout_o(cout)
  );

  eas_ctrl #(.DW(DW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .wr_i, .opnd_i, .x_i, .y_i, .pc_i, .wdata_i,
    .rdata_i(bus_rdata_i), .sum_i(sum), .cout_i(cout),
    .st_o(st), .mode_o(mode_q), .wr_o(wr_q), .opnd_o(opnd_q), .idx_o(idx_q),
    .pc_o(pc_q), .base_o(base_q), .wdata_o(wdata_q), .ptr_lo_o(ptr_lo_q),
    .done_o, .ea_o, .data_o, .pcr_o(pc_o), .cyc_o(cycles_o)
  );

  eas_bus_gen #(.DW(DW)) u_bus (
    .st_i(st), .mode_i(mode_q), .wr_i(wr_q), .opnd_i(opnd_q), .idx_i(idx_q),
    .pc_i(pc_q), .base_i(base_q), .wdata_i(wdata_q),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o)
  );
endmodule

// File: rtl/eas_chk.sv
module eas_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 3,
  localparam int AW   = 2 * DW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [3:0]       mode_i,
  input logic             busy_o,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic [AW-1:0]    bus_addr_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cycles_o
);
  logic [3:0]       mode_c;
  logic [CNT_W-1:0] cnt_c;
  logic             accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_c <= '0;
      cnt_c  <= '0;
    end else if (accept) begin
      mode_c <= mode_i;
      cnt_c  <= '0;
    end else if (bus_req_o) begin
      cnt_c <= cnt_c + CNT_W'(1);
    end
  end

  // R1
  always_comb if (!rst_ni) reset_quiet_chk : assert (!bus_req_o && !done_o);

  // R11
  done_pulse_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  cyc_match_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cycles_o == cnt_c);

  // R3
  zp_page_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && mode_c <= 4'd2) |-> bus_addr_o[AW-1:DW] == '0);

  // R6
  write_last_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_req_o);

  // R6
  write_mode_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> mode_c <= 4'd7);

  // R13
  bad_mode_chk : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i >= 4'd10) |=> (done_o && !bus_req_o));
endmodule

bind ea_sequencer eas_chk #(.DW(DW), .CNT_W(CNT_W)) u_eas_chk (
  .clk_i, .rst_ni, .start_i, .mode_i, .busy_o, .bus_req_o, .bus_we_o,
  .bus_addr_o, .done_o, .cycles_o
);

// File: tb/test_ea_sequencer.sv
module test_ea_sequencer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, wr = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd = '0, xr = '0, yr = '0, wd = '0, rdata;
  logic [15:0] pc = '0;
  logic        req, we, busy, done;
  logic [15:0] addr, ea, pco;
  logic [7:0]  bwd, dat;
  logic [2:0]  cyc;
  int errors = 0, checks = 0;
  bit finished = 0;

  logic [24:0] exp_bus[$];
  string       bus_tag[$];
  logic [42:0] exp_res[$];
  string       res_tag[$];

  always #2 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rdata = mem(addr);

  ea_sequencer i_ea_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .wr_i(wr),
    .opnd_i(opnd), .x_i(xr), .y_i(yr), .pc_i(pc), .wdata_i(wd),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(bwd),
    .bus_rdata_i(rdata), .busy_o(busy), .done_o(done), .ea_o(ea), .data_o(dat),
    .pc_o(pco), .cycles_o(cyc)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pb(input logic w, input logic [15:0] a, input logic [7:0] d, input string t);
    exp_bus.push_back({w, a, w ? d : 8'h00});
    bus_tag.push_back(t);
  endtask

  task automatic pr(input logic [15:0] e, input logic [7:0] d, input logic [15:0] p,
                    input logic [2:0] c, input string t);
    exp_res.push_back({e, d, p, c});
    res_tag.push_back(t);
  endtask

  // expected behaviour written from the requirements
  task automatic model(input logic [3:0] m, input logic w, input logic [7:0] op,
                       input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                       input logic [7:0] d);
    logic [8:0]  s;
    logic [7:0]  hi, lo, ix, z;
    logic [15:0] a, t;
    ix = (m == 4'd1 || m == 4'd4 || m == 4'd6) ? x : y;
    case (m)
      4'd0: begin pb(0, {8'h00, op}, 0, "R2"); pr({8'h00, op}, mem({8'h00, op}), p, 1, "R2"); end
      4'd1, 4'd2: begin
        z = op + ix;
        pb(0, {8'h00, op}, 0, "R3");
        pb(w, {8'h00, z}, d, "R3");
        pr({8'h00, z}, w ? d : mem({8'h00, z}), p, 2, "R3");
      end
      4'd3: begin
        hi = mem(p); a = {hi, op};
        pb(0, p, 0, "R4"); pb(w, a, d, "R4");
        pr(a, w ? d : mem(a), p + 1, 2, "R4");
      end
      4'd4, 4'd5, 4'd7: begin
        if (m == 4'd7) begin
          pb(0, {8'h00, op}, 0, "R8"); pb(0, {8'h00, 8'(op + 1)}, 0, "R8");
          lo = mem({8'h00, op}); hi = mem({8'h00, 8'(op + 1)});
        end else begin
          pb(0, p, 0, "R5"); lo = op; hi = mem(p);
        end
        s = {1'b0, lo} + {1'b0, ix};
        a = {hi, s[7:0]};
        if (s[8]) begin pb(0, a, 0, w ? "R6" : "R5"); a = a + 16'h0100; end
        pb(w, a, d, w ? "R6" : "R5");
        pr(a, w ? d : mem(a), (m == 4'd7) ? p : p + 1,
           3'((m == 4'd7 ? 3 : 2) + int'(s[8])), m == 4'd7 ? "R8" : "R5");
      end
      4'd6: begin
        z = op + x;
        pb(0, {8'h00, op}, 0, "R7");
        pb(0, {8'h00, z}, 0, "R7"); pb(0, {8'h00, 8'(z + 1)}, 0, "R7");
        a = {mem({8'h00, 8'(z + 1)}), mem({8'h00, z})};
        pb(w, a, d, "R7");
        pr(a, w ? d : mem(a), p, 4, "R7");
      end
      4'd8: begin
        t = p + {{8{op[7]}}, op};
        pb(0, {p[15:8], t[7:0]}, 0, "R9");
        if (t[15:8] != p[15:8]) pb(0, {p[15:8], t[7:0]}, 0, "R9");
        pr(t, 0, t, (t[15:8] != p[15:8]) ? 3'd2 : 3'd1, "R9");
      end
      4'd9: begin
        hi = mem(p); a = {hi, op};
        pb(0, p, 0, "R10"); pb(0, a, 0, "R10"); pb(0, {hi, 8'(op + 1)}, 0, "R10");
        t = {mem({hi, 8'(op + 1)}), mem(a)};
        pr(t, 0, t, 3, "R10");
      end
      default: pr(0, 0, p, 0, "R13");
    endcase
  endtask

  task automatic run(input logic [3:0] m, input logic w, input logic [7:0] op,
                     input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                     input logic [7:0] d, input bit poke);
    model(m, w, op, x, y, p, d);
    mode = m; wr = w; opnd = op; xr = x; yr = y; pc = p; wd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R12: a start while busy must leave the running operation unchanged
      start = 1'b1; mode = 4'd0; opnd = ~op; wr = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (req) begin
      if (exp_bus.size() == 0) chk("R11 unexpected access", {we, addr, bwd}, 48'h0);
      else chk(bus_tag.pop_front(), {we, addr, we ? bwd : 8'h00}, exp_bus.pop_front());
    end
    if (done) begin
      chk("R11 accesses left", exp_bus.size(), 0);
      if (exp_res.size() == 0) chk("R11 unexpected done", 1, 0);
      else chk(res_tag.pop_front(), {ea, dat, pco, cyc}, exp_res.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {req, done, ea, dat, pco, 1'b0, cyc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {req, done, busy, ea, dat}, 0);
    run(4'd0, 0, 8'h37, 8'h00, 8'h00, 16'h0400, 8'h00, 0);
    run(4'd1, 0, 8'hF0, 8'h20, 8'h00, 16'h0400, 8'h00, 0); // R3 wrap
    run(4'd2, 1, 8'h10, 8'h00, 8'h05, 16'h0400, 8'h5C, 0);
    run(4'd3, 0, 8'h44, 8'h00, 8'h00, 16'h1234, 8'h00, 0);
    run(4'd3, 1, 8'h44, 8'h00, 8'h00, 16'h2000, 8'h77, 0);
    run(4'd4, 0, 8'h10, 8'h05, 8'h00, 16'h3000, 8'h00, 0); // R5 no carry
    run(4'd4, 0, 8'hF0, 8'h20, 8'h00, 16'h3000, 8'h00, 0); // R5 carry
    run(4'd5, 0, 8'h80, 8'h00, 8'h90, 16'h3100, 8'h00, 0);
    run(4'd4, 1, 8'h10, 8'h01, 8'h00, 16'h3000, 8'h11, 0); // R6 direct
    run(4'd5, 1, 8'hFF, 8'h00, 8'h01, 16'h3000, 8'h22, 0); // R6 carry
    run(4'd6, 0, 8'h20, 8'h04, 8'h00, 16'h0500, 8'h00, 0);
    run(4'd6, 1, 8'hFE, 8'h01, 8'h00, 16'h0500, 8'h33, 0); // R7 pointer wrap
    run(4'd7, 0, 8'h40, 8'h00, 8'h00, 16'h0500, 8'h00, 0); // R8 no carry
    run(4'd7, 0, 8'h40, 8'h00, 8'hFF, 16'h0500, 8'h00, 0); // R8 carry
    run(4'd7, 1, 8'hFF, 8'h00, 8'hFF, 16'h0500, 8'h44, 0); // R8 pointer wrap, R6 write
    run(4'd8, 0, 8'h05, 8'h00, 8'h00, 16'h1230, 8'h00, 0); // R9 same page
    run(4'd8, 0, 8'h20, 8'h00, 8'h00, 16'h12F0, 8'h00, 0); // R9 forward cross
    run(4'd8, 0, 8'h80, 8'h00, 8'h00, 16'h1230, 8'h00, 0); // R9 backward cross
    run(4'd9, 0, 8'h30, 8'h00, 8'h00, 16'h4000, 8'h00, 0);
    run(4'd9, 0, 8'hFF, 8'h00, 8'h00, 16'h4100, 8'h00, 0); // R10 no page carry
    run(4'd6, 0, 8'h08, 8'h02, 8'h00, 16'h0600, 8'h00, 1); // R12
    run(4'd12, 0, 8'h08, 8'h00, 8'h00, 16'h0777, 8'h00, 0); // R13
    run(4'd15, 1, 8'h08, 8'h00, 8'h00, 16'h0888, 8'h00, 0); // R13
    repeat (3) @(negedge clk);
    chk("R11 results left", exp_res.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule